// File: doc/BRIEF.md
# Diagonal-Order Wide Integer Multiplier

This block forms the full 1024-bit unsigned product of two 512-bit operands. Each operand is held as eight 64-bit words. The multiplication runs one row at a time: in each row every word of the first operand (A) is multiplied by a single word of the second operand (B). A bank of eight 64-bit running-sum registers carries the partially accumulated result from one row to the next.

Each row uses two separate carry chains that advance in the same cycle. The first chain joins the high half of each word product to the low half of the next product in the same row. The second chain adds that joined row into the running sum. One word product is formed per cycle. A row therefore takes eight multiply steps plus one step that resolves the final carries.

When a row ends, its least significant word is final and is emitted at once. The remaining words shift down one place in the register bank. After the last row, the eight register words are streamed out as the upper half of the product.

Operands are written one word at a time while the engine is idle. A start pulse launches a run. The sixteen result words come out on a 64-bit port with a valid strobe and a word number. A done pulse marks the last word.

Top module: `wide_rowmul`

## Requirements
- R1: Synchronous active-low reset clears `busy`, `done` and `res_valid` to 0 on the first clock edge at which `rst_n` is low, also when a run is in progress.
- R2: While idle, `ld_en` high writes `ld_word` into word `ld_idx` of A when `ld_sel` is 0, or of B when `ld_sel` is 1, with word 0 being least significant. Writes presented while `busy` is high are dropped and leave the stored operands unchanged.
- R3: `start` sampled high while idle sets `busy` on the same edge. `start` sampled while `busy` is high has no effect on the run in progress. `busy` returns low one cycle after `done`.
- R4: The sixteen output words equal the product A×B, where word k carries product bits [64k+63:64k].
- R5: Word k is presented with `res_idx` = k, in increasing order. Counting the edge that samples `start` as edge 0, words 0..7 are valid on edge 9k+1 and words 8..15 on edge k+65. Each word is valid for one cycle.
- R6: `done` is high for exactly one cycle per run, in the cycle that presents word 15.
- R7: Both carry chains are clear at the first step of every row. The resolve step of a row never produces a carry out of either chain, including for all-ones operands.
- R8: Operands are kept after a run, so a second `start` with no reload yields the same product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Operand word write strobe |
| ld_sel | input | 1 | Operand select: 0 = A, 1 = B |
| ld_idx | input | 3 | Word number to write |
| ld_word | input | 64 | Operand word data |
| start | input | 1 | Launches a multiplication when idle |
| busy | output | 1 | High from launch until one cycle after done |
| done | output | 1 | One-cycle pulse with the last result word |
| res_valid | output | 1 | Result word strobe |
| res_idx | output | 4 | Number of the presented result word |
| res_data | output | 64 | Result word |

## Verification
The hardest case to reach is a row in which both carry chains ripple across every word and still leave nothing past the top word. Only operands with long runs of ones, such as all-ones times all-ones, push the running sum against that bound. The stimulus table therefore includes those operands alongside a single top-bit operand, structured patterns and random words. It also issues a stray start and a stray load part-way through a run, then runs again without reloading. This shows at the ports that neither the result nor the stored operands were disturbed.

// File: rtl/rowmul_pkg.sv
// Shared defaults and the control state type for the diagonal multiplier.
package rowmul_pkg;
    localparam int RM_WORD_W    = 64;
    localparam int RM_NUM_WORDS = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2,
        ST_FIN   = 2'd3
    } rm_state_e;
endpackage

// File: rtl/rowmul_opstore.sv
// Operand word store for A and B.
// Assumes: writes are accepted only while lock is low; one read port per operand.
module rowmul_opstore #(
    parameter int WORD_W    = rowmul_pkg::RM_WORD_W,
    parameter int NUM_WORDS = rowmul_pkg::RM_NUM_WORDS,
    localparam int IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock,
    input  logic              ld_en,
    input  logic              ld_sel,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [WORD_W-1:0] ld_word,
    input  logic [IDX_W-1:0]  a_idx,
    input  logic [IDX_W-1:0]  b_idx,
    output logic [WORD_W-1:0] a_word,
    output logic [WORD_W-1:0] b_word
);
    logic [NUM_WORDS-1:0][WORD_W-1:0] a_q;
    logic [NUM_WORDS-1:0][WORD_W-1:0] b_q;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        // Write one word of A or B when the store is unlocked.
        always_ff @(posedge clk) begin
            if (ld_en && !lock && ld_idx == IDX_W'(w)) begin
                if (ld_sel) b_q[w] <= ld_word;
                else        a_q[w] <= ld_word;
            end
        end
    end

    // Read ports feeding the multiplier.
    assign a_word = a_q[a_idx];
    assign b_word = b_q[b_idx];

    // R2: stored operands do not change while a run holds the lock.
    assert_hold_operands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> ($stable(a_q) && $stable(b_q)));
endmodule

// File: rtl/rowmul_ctrl.sv
// Sequencer: walks rows (B words) and steps (A words plus one resolve step),
// then streams the running-sum bank out.
// Assumes: start is honoured only in idle.
module rowmul_ctrl #(
    parameter int NUM_WORDS = rowmul_pkg::RM_NUM_WORDS,
    localparam int IDX_W    = $clog2(NUM_WORDS),
    localparam int STEP_W   = $clog2(NUM_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              clr,
    output logic              step_en,
    output logic [IDX_W-1:0]  diag_idx,
    output logic [STEP_W-1:0] step_idx,
    output logic              flush_en,
    output logic [IDX_W-1:0]  flush_idx
);
    import rowmul_pkg::*;

    rm_state_e state_q;
    logic      last_step;
    logic      last_diag;

    assign last_step = (step_idx == STEP_W'(NUM_WORDS));
    assign last_diag = (diag_idx == IDX_W'(NUM_WORDS - 1));

    // State register and row/step/flush counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            diag_idx  <= '0;
            step_idx  <= '0;
            flush_idx <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    state_q  <= ST_RUN;
                    diag_idx <= '0;
                    step_idx <= '0;
                end
                ST_RUN: if (last_step) begin
                    step_idx <= '0;
                    if (last_diag) begin
                        state_q   <= ST_FLUSH;
                        flush_idx <= '0;
                    end else begin
                        diag_idx <= diag_idx + 1'b1;
                    end
                end else begin
                    step_idx <= step_idx + 1'b1;
                end
                ST_FLUSH: begin
                    if (flush_idx == IDX_W'(NUM_WORDS - 1)) state_q <= ST_FIN;
                    flush_idx <= flush_idx + 1'b1;
                end
                ST_FIN: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Decoded control strobes.
    always_comb begin
        busy     = (state_q != ST_IDLE);
        done     = (state_q == ST_FIN);
        clr      = (state_q == ST_IDLE) && start;
        step_en  = (state_q == ST_RUN);
        flush_en = (state_q == ST_FLUSH);
    end
endmodule

// File: rtl/rowmul_diag_dp.sv
// Row datapath: one word product per step, a product-joining carry chain and
// an accumulation carry chain, and the running-sum bank that shifts down a
// word per row.
// Assumes: clr precedes the first row; resolve step is step NUM_WORDS.
module rowmul_diag_dp #(
    parameter int WORD_W    = rowmul_pkg::RM_WORD_W,
    parameter int NUM_WORDS = rowmul_pkg::RM_NUM_WORDS,
    localparam int IDX_W    = $clog2(NUM_WORDS),
    localparam int STEP_W   = $clog2(NUM_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step_en,
    input  logic [STEP_W-1:0] step_idx,
    input  logic [WORD_W-1:0] a_word,
    input  logic [WORD_W-1:0] b_word,
    input  logic [IDX_W-1:0]  flush_idx,
    output logic [WORD_W-1:0] sum_word,
    output logic [WORD_W-1:0] bank_word
);
    logic [2*WORD_W-1:0]              prod;
    logic [WORD_W-1:0]                hi_q;
    logic                             c_join_q;
    logic                             c_acc_q;
    logic [NUM_WORDS-1:0][WORD_W-1:0] bank_q;
    logic                             resolve;
    logic [WORD_W-1:0]                lo_term;
    logic [WORD_W-1:0]                bank_term;
    logic [WORD_W:0]                  join_sum;
    logic [WORD_W:0]                  acc_sum;

    // Word product and both carry-chain adders for the current step.
    always_comb begin
        prod      = a_word * b_word;
        resolve   = (step_idx == STEP_W'(NUM_WORDS));
        lo_term   = resolve ? '0 : prod[WORD_W-1:0];
        bank_term = resolve ? '0 : bank_q[step_idx[IDX_W-1:0]];
        join_sum  = {1'b0, lo_term} + {1'b0, hi_q} + (WORD_W+1)'(c_join_q);
        acc_sum   = {1'b0, join_sum[WORD_W-1:0]} + {1'b0, bank_term}
                    + (WORD_W+1)'(c_acc_q);
    end

    assign sum_word  = acc_sum[WORD_W-1:0];
    assign bank_word = bank_q[flush_idx];

    // Carry bits and pending high half; cleared at launch and after each row.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            hi_q     <= '0;
            c_join_q <= 1'b0;
            c_acc_q  <= 1'b0;
        end else if (step_en) begin
            hi_q     <= resolve ? '0 : prod[2*WORD_W-1:WORD_W];
            c_join_q <= resolve ? 1'b0 : join_sum[WORD_W];
            c_acc_q  <= resolve ? 1'b0 : acc_sum[WORD_W];
        end
    end

    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_bank
        // Running-sum word k: cleared at launch, written one place down.
        always_ff @(posedge clk) begin
            if (clr)
                bank_q[k] <= '0;
            else if (step_en && step_idx == STEP_W'(k + 1))
                bank_q[k] <= sum_word;
        end
    end

    // R7: every row starts with both chains and the pending high half clear.
    assert_chains_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && step_idx == '0) |-> (hi_q == '0 && !c_join_q && !c_acc_q));

    // R7: the resolve step never carries out of the top word.
    assert_top_word_fits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && resolve) |-> (!join_sum[WORD_W] && !acc_sum[WORD_W]));
endmodule

// File: rtl/wide_rowmul.sv
// Top: operand store, sequencer, row datapath and the registered result port.
// Assumes: NUM_WORDS is a power of two so the result index is one bit wider
// than the word index.
module wide_rowmul #(
    parameter int WORD_W    = rowmul_pkg::RM_WORD_W,
    parameter int NUM_WORDS = rowmul_pkg::RM_NUM_WORDS,
    localparam int IDX_W    = $clog2(NUM_WORDS),
    localparam int STEP_W   = $clog2(NUM_WORDS + 1),
    localparam int OUT_W    = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic              ld_sel,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [WORD_W-1:0] ld_word,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              res_valid,
    output logic [OUT_W-1:0]  res_idx,
    output logic [WORD_W-1:0] res_data
);
    logic              clr;
    logic              step_en;
    logic              flush_en;
    logic [IDX_W-1:0]  diag_idx;
    logic [STEP_W-1:0] step_idx;
    logic [IDX_W-1:0]  flush_idx;
    logic [WORD_W-1:0] a_word;
    logic [WORD_W-1:0] b_word;
    logic [WORD_W-1:0] sum_word;
    logic [WORD_W-1:0] bank_word;

    rowmul_opstore #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_store (
        .clk(clk), .rst_n(rst_n), .lock(busy),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_idx(ld_idx), .ld_word(ld_word),
        .a_idx(step_idx[IDX_W-1:0]), .b_idx(diag_idx),
        .a_word(a_word), .b_word(b_word)
    );

    rowmul_ctrl #(.NUM_WORDS(NUM_WORDS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .busy(busy), .done(done), .clr(clr), .step_en(step_en),
        .diag_idx(diag_idx), .step_idx(step_idx),
        .flush_en(flush_en), .flush_idx(flush_idx)
    );

    rowmul_diag_dp #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_dp (
        .clk(clk), .rst_n(rst_n), .clr(clr), .step_en(step_en),
        .step_idx(step_idx), .a_word(a_word), .b_word(b_word),
        .flush_idx(flush_idx), .sum_word(sum_word), .bank_word(bank_word)
    );

    // Result register: retired row word on step 0, bank words while flushing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_idx   <= '0;
            res_data  <= '0;
        end else begin
            res_valid <= 1'b0;
            if (step_en && step_idx == '0) begin
                res_valid <= 1'b1;
                res_idx   <= {1'b0, diag_idx};
                res_data  <= sum_word;
            end else if (flush_en) begin
                res_valid <= 1'b1;
                res_idx   <= {1'b1, flush_idx};
                res_data  <= bank_word;
            end
        end
    end

    // R6: done lasts a single cycle.
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: done coincides with the top result word.
    assert_done_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (res_valid && res_idx == {OUT_W{1'b1}}));

    // R5: back-to-back result words have consecutive numbers.
    assert_idx_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(res_valid)) |-> (res_idx == $past(res_idx) + 1'b1));
endmodule

// File: tb/wide_rowmul_tb.sv
module wide_rowmul_tb;
    localparam int NVEC = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic        ld_sel = 1'b0;
    logic [2:0]  ld_idx = '0;
    logic [63:0] ld_word = '0;
    logic        start = 1'b0;
    logic        busy;
    logic        done;
    logic        res_valid;
    logic [3:0]  res_idx;
    logic [63:0] res_data;

    int n_tests = 0;
    int n_fail  = 0;

    // Stimulus table: {A, B}; the expected product is formed at run time.
    localparam logic [1023:0] VEC [NVEC] = '{
        {{512{1'b1}}, {512{1'b1}}},
        {512'd1, {512{1'b1}}},
        {{8{64'hFFFF_FFFF_FFFF_FFFE}}, {8{64'h8000_0000_0000_0001}}},
        {{4{128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210}},
         {2{256'h9E37_79B9_7F4A_7C15_F39C_C060_5CED_C834_1082_2769_13B4_6A5D_C4F1_0E2B_77A3_9D01}}},
        {512'd0, {8{64'hA5A5_5A5A_C3C3_3C3C}}},
        {{1'b1, 511'd0}, {512{1'b1}}}
    };

    wide_rowmul u_dut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel),
        .ld_idx(ld_idx), .ld_word(ld_word), .start(start),
        .busy(busy), .done(done), .res_valid(res_valid),
        .res_idx(res_idx), .res_data(res_data)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic load_ops(input logic [511:0] a, input logic [511:0] b);
        for (int w = 0; w < 16; w++) begin
            @(negedge clk);
            ld_en   = 1'b1;
            ld_sel  = (w >= 8);
            ld_idx  = 3'(w % 8);
            ld_word = (w < 8) ? a[64*w +: 64] : b[64*(w-8) +: 64];
        end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // Launch, then check every output word, its timing, done and busy.
    task automatic run_chk(input logic [511:0] a, input logic [511:0] b,
                           input string tag, input bit poke);
        logic [1023:0] exp_p;
        int got;
        int strays;
        exp_p  = {512'd0, a} * {512'd0, b};
        got    = 0;
        strays = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy == 1'b1, "R3", "busy after start", 64'(busy), 64'd1);
        for (int n = 0; n < 86; n++) begin
            if (poke && n == 20) begin
                start = 1'b1; ld_en = 1'b1; ld_sel = 1'b0;
                ld_idx = 3'd3; ld_word = 64'h0BAD_0BAD_0BAD_0BAD;
            end
            if (poke && n == 21) begin
                start = 1'b0; ld_en = 1'b0;
            end
            if (res_valid) begin
                if (got < 16) begin
                    chk(res_idx == 4'(got), "R5", "word order", 64'(res_idx), 64'(got));
                    chk(n == ((got < 8) ? 9*got + 1 : got + 65), "R5", "word timing",
                        64'(n), 64'((got < 8) ? 9*got + 1 : got + 65));
                    chk(res_data == exp_p[64*got +: 64], tag, "product word",
                        res_data, exp_p[64*got +: 64]);
                end
                got++;
            end
            if (n == 80) chk(done == 1'b1, "R6", "done with last word", 64'(done), 64'd1);
            else if (done) strays++;
            @(negedge clk);
        end
        chk(got == 16, "R5", "word count", 64'(got), 64'd16);
        chk(strays == 0, "R6", "stray done", 64'(strays), 64'd0);
        chk(busy == 1'b0, "R3", "idle after run", 64'(busy), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R5 watchdog expired: actual running expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
        $finish;
    end

    initial begin
        logic [511:0] ra;
        logic [511:0] rb;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0, "R1", "busy in reset", 64'(busy), 64'd0);
        chk(done == 1'b0, "R1", "done in reset", 64'(done), 64'd0);
        chk(res_valid == 1'b0, "R1", "valid in reset", 64'(res_valid), 64'd0);
        rst_n = 1'b1;

        // Table walk: R4 data, R7 all-ones carry stress
        for (int v = 0; v < NVEC; v++) begin
            load_ops(VEC[v][1023:512], VEC[v][511:0]);
            run_chk(VEC[v][1023:512], VEC[v][511:0], (v == 0) ? "R7" : "R4", 1'b0);
        end

        // Random operands (R4)
        for (int r = 0; r < 4; r++) begin
            for (int w = 0; w < 16; w++) begin
                ra[32*w +: 32] = $urandom;
                rb[32*w +: 32] = $urandom;
            end
            load_ops(ra, rb);
            run_chk(ra, rb, "R4", 1'b0);
        end

        // R3/R2: stray start and load mid-run are ignored
        run_chk(ra, rb, "R3", 1'b1);
        // R8/R2: rerun without reload gives the same product
        run_chk(ra, rb, "R8", 1'b0);

        // R1: reset in the middle of a run
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R1", "busy after mid-run reset", 64'(busy), 64'd0);
        chk(res_valid == 1'b0, "R1", "valid after mid-run reset", 64'(res_valid), 64'd0);
        chk(done == 1'b0, "R1", "done after mid-run reset", 64'(done), 64'd0);
        rst_n = 1'b1;
        run_chk(ra, rb, "R1", 1'b0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule